// File: doc/BRIEF.md
# VID decoder with delayed power-good

This block turns a 5-bit voltage identification code into the millivolt target of a core supply, and watches a digitised feedback sample against that target to produce a power-good flag. One code value means that the output is switched off. The code inputs are filtered, so that bits which flip at slightly different times during a dynamic voltage change never produce a short-lived false target.

The flag compares the latest feedback sample with 88 % of the currently accepted target. It becomes good on the edge after the output is within range. It becomes bad only after the output has stayed below the threshold for a long qualification window. This lets dynamic code changes and short dips pass without a glitch on the flag. While the output is disabled, forced off by a fault, or programmed off, the flag is low. The sample converter, the voltage reference and the open-collector pad are outside the block.

Top module: `vid_pgood`

## Requirements
- R1: For an accepted code c in 0..30, `target_mv` equals 1100 + 25*(30 - c) in binary millivolts (code 0 gives 1850, code 30 gives 1100) and `out_off` is 0.
- R2: An accepted code of 31 (all ones) drives `out_off` to 1 and `target_mv` to 0.
- R3: A new `vid_code` value is accepted on the rising edge at which it has been sampled, unchanged, on STABLE_CYC+1 consecutive rising edges. A value held for fewer edges leaves the accepted code unchanged.
- R4: The feedback counts as low when fb*100 < target_mv*88. Here fb is the `fb_mv` value captured on the most recent edge with `fb_valid` = 1, and it resets to 0. `fb_mv` is ignored while `fb_valid` is 0.
- R5: When the block is active (enable = 1, fault_off = 0, out_off = 0) and the feedback is not low, `pwr_ok` is 1 after the next rising edge.
- R6: While `pwr_ok` is 1 and the block is active, `pwr_ok` falls only on the DELAY_CYC-th consecutive edge at which the feedback is low. A single edge with the feedback in range restarts the count.
- R7: When enable = 0, fault_off = 1 or out_off = 1 is sampled on an edge, `pwr_ok` is 0 after that edge.
- R8: The threshold always uses the currently accepted target, so a change of code moves the threshold as soon as the code is accepted.
- R9: After reset, `target_mv` = 0, `out_off` = 1 and `pwr_ok` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| vid_code | input | 5 | Raw voltage identification code |
| fb_mv | input | FB_W | Feedback sample in millivolts |
| fb_valid | input | 1 | Strobe that captures `fb_mv` |
| enable | input | 1 | Output enable, high to run |
| fault_off | input | 1 | Forces the output off while high |
| target_mv | output | 12 | Accepted target voltage in millivolts, 0 when off |
| out_off | output | 1 | High when the accepted code is the off code |
| pwr_ok | output | 1 | Power-good, high when good |

## Verification
The assertions assume that `vid_code` changes only between clock edges and that the feedback only ever holds values that the block would see from a converter. After a change of code, they also assume the input has been driven for at least two cycles since reset. The stimulus changes every input on the falling edge. It holds each code long enough to be accepted, except where a glitch shorter than the filter window is intended. The feedback values are chosen to sit on either side of the 88 % boundary, including the exact boundary product. Persistence runs are made both shorter and longer than the delay, so that the restart and the drop are both exercised.

// File: rtl/vidpg_pkg.sv
package vidpg_pkg;

    localparam int VID_W    = 5;
    localparam int MV_W     = 12;
    localparam int BASE_MV  = 1100;
    localparam int STEP_MV  = 25;
    localparam int TOP_IDX  = 30;
    localparam int PG_NUM   = 88;
    localparam int PG_DEN   = 100;
    localparam logic [VID_W-1:0] OFF_CODE = '1;

    typedef struct packed {
        logic            off;
        logic [MV_W-1:0] mv;
    } vid_target_t;

    typedef enum logic {
        PG_BAD  = 1'b0,
        PG_GOOD = 1'b1
    } pg_state_e;

    function automatic vid_target_t vid_lookup(input logic [VID_W-1:0] code);
        vid_target_t r;
        int idx;
        idx = TOP_IDX - int'(code);
        if (code == OFF_CODE) begin
            r.off = 1'b1;
            r.mv  = '0;
        end else begin
            r.off = 1'b0;
            r.mv  = MV_W'(BASE_MV + STEP_MV * idx);
        end
        return r;
    endfunction

endpackage

// File: rtl/vid_filter.sv
module vid_filter
    import vidpg_pkg::*;
#(
    parameter int STABLE_CYC = 63
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [VID_W-1:0] code_in,
    output logic [VID_W-1:0] code_acc
);
    localparam int CW = $clog2(STABLE_CYC + 1);

    logic [VID_W-1:0] last_q;
    logic [CW-1:0]    run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q   <= OFF_CODE;
            run_q    <= '0;
            code_acc <= OFF_CODE;
        end else if (code_in != last_q) begin
            last_q <= code_in;
            run_q  <= '0;
        end else begin
            if (run_q < CW'(STABLE_CYC))
                run_q <= run_q + 1'b1;
            if (run_q == CW'(STABLE_CYC - 1))
                code_acc <= last_q;
        end
    end
endmodule

// File: rtl/vid_decode.sv
module vid_decode
    import vidpg_pkg::*;
(
    input  logic [VID_W-1:0] code,
    output vid_target_t      tgt
);
    always_comb tgt = vid_lookup(code);
endmodule

// File: rtl/pg_threshold.sv
module pg_threshold
    import vidpg_pkg::*;
#(
    parameter int FB_W = 12
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [FB_W-1:0] fb_mv,
    input  logic            fb_valid,
    input  logic [MV_W-1:0] target_mv,
    output logic            below
);
    localparam int FBP = FB_W + 7;
    localparam int TGP = MV_W + 7;
    localparam int PW  = (FBP > TGP) ? FBP : TGP;

    logic [FB_W-1:0] fb_q;
    logic [PW-1:0]   fb_scaled;
    logic [PW-1:0]   tg_scaled;

    always_ff @(posedge clk) begin
        if (rst)
            fb_q <= '0;
        else if (fb_valid)
            fb_q <= fb_mv;
    end

    always_comb begin
        fb_scaled = PW'(fb_q) * PW'(PG_DEN);
        tg_scaled = PW'(target_mv) * PW'(PG_NUM);
        below     = fb_scaled < tg_scaled;
    end
endmodule

// File: rtl/pg_timer.sv
module pg_timer
    import vidpg_pkg::*;
#(
    parameter int DELAY_CYC = 62500
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic below,
    output logic pwr_ok
);
    localparam int CW = $clog2(DELAY_CYC + 1);

    pg_state_e     st_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            st_q  <= PG_BAD;
            cnt_q <= '0;
        end else if (!below) begin
            st_q  <= PG_GOOD;
            cnt_q <= '0;
        end else if (st_q == PG_GOOD) begin
            if (cnt_q == CW'(DELAY_CYC - 1)) begin
                st_q  <= PG_BAD;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign pwr_ok = (st_q == PG_GOOD);
endmodule

// File: rtl/vid_pgood.sv
module vid_pgood
    import vidpg_pkg::*;
#(
    parameter int STABLE_CYC = 63,
    parameter int DELAY_CYC  = 62500,
    parameter int FB_W       = 12
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [4:0]      vid_code,
    input  logic [FB_W-1:0] fb_mv,
    input  logic            fb_valid,
    input  logic            enable,
    input  logic            fault_off,
    output logic [11:0]     target_mv,
    output logic            out_off,
    output logic            pwr_ok
);
    logic [VID_W-1:0] code_acc;
    vid_target_t      tgt;
    logic             fb_below;
    logic             active;

    vid_filter #(.STABLE_CYC(STABLE_CYC)) u_filt (
        .clk(clk), .rst(rst), .code_in(vid_code), .code_acc(code_acc)
    );

    vid_decode u_dec (.code(code_acc), .tgt(tgt));

    pg_threshold #(.FB_W(FB_W)) u_thr (
        .clk(clk), .rst(rst), .fb_mv(fb_mv), .fb_valid(fb_valid),
        .target_mv(tgt.mv), .below(fb_below)
    );

    assign active = enable && !fault_off && !tgt.off;

    pg_timer #(.DELAY_CYC(DELAY_CYC)) u_tmr (
        .clk(clk), .rst(rst), .active(active), .below(fb_below), .pwr_ok(pwr_ok)
    );

    assign target_mv = tgt.mv;
    assign out_off   = tgt.off;
endmodule

// File: rtl/vid_pgood_chk.sv
module vid_pgood_chk #(
    parameter int DELAY_CYC = 62500
) (
    input logic        clk,
    input logic        rst,
    input logic [4:0]  vid_code,
    input logic        enable,
    input logic        fault_off,
    input logic [11:0] target_mv,
    input logic        out_off,
    input logic        pwr_ok,
    input logic        fb_below
);
    localparam int RW = $clog2(DELAY_CYC + 1);

    logic          act;
    logic [RW-1:0] low_run;

    assign act = enable && !fault_off && !out_off;

    always_ff @(posedge clk) begin
        if (rst)
            low_run <= '0;
        else if (act && pwr_ok && fb_below && low_run < RW'(DELAY_CYC))
            low_run <= low_run + 1'b1;
        else
            low_run <= '0;
    end

    // R1
    p_target_range_r1: assert property (@(posedge clk) disable iff (rst)
        !out_off |-> (target_mv >= 12'd1100 && target_mv <= 12'd1850 &&
                      ((target_mv - 12'd1100) % 12'd25) == 12'd0));

    // R2
    p_off_zero_r2: assert property (@(posedge clk) disable iff (rst)
        out_off |-> target_mv == 12'd0);

    // R3
    p_code_settled_r3: assert property (@(posedge clk) disable iff (rst)
        !$stable(target_mv) |-> $past(vid_code) == $past(vid_code, 2));

    // R5
    p_rise_next_r5: assert property (@(posedge clk) disable iff (rst)
        (act && !fb_below) |=> pwr_ok);

    // R6
    p_hold_early_r6: assert property (@(posedge clk) disable iff (rst)
        (act && pwr_ok && fb_below && low_run < RW'(DELAY_CYC - 1)) |=> pwr_ok);

    // R6
    p_drop_late_r6: assert property (@(posedge clk) disable iff (rst)
        (act && pwr_ok && fb_below && low_run == RW'(DELAY_CYC - 1)) |=> !pwr_ok);

    // R7
    p_inactive_low_r7: assert property (@(posedge clk) disable iff (rst)
        !act |=> !pwr_ok);
endmodule

bind vid_pgood vid_pgood_chk #(.DELAY_CYC(DELAY_CYC)) u_chk (
    .clk(clk), .rst(rst), .vid_code(vid_code), .enable(enable),
    .fault_off(fault_off), .target_mv(target_mv), .out_off(out_off),
    .pwr_ok(pwr_ok), .fb_below(fb_below)
);

// File: tb/tb_vid_pgood.sv
module tb_vid_pgood;
    localparam int STB = 4;
    localparam int DLY = 40;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  vid_code = 5'd31;
    logic [11:0] fb_mv = '0;
    logic        fb_valid = 1'b0;
    logic        enable = 1'b0;
    logic        fault_off = 1'b0;
    logic [11:0] target_mv;
    logic        out_off;
    logic        pwr_ok;

    int vectors = 0;
    int fails = 0;
    bit checking = 0;
    bit done = 0;
    string cur_req = "R9";

    always #4 clk = ~clk;

    vid_pgood #(.STABLE_CYC(STB), .DELAY_CYC(DLY), .FB_W(12)) dut (
        .clk(clk), .rst(rst), .vid_code(vid_code), .fb_mv(fb_mv),
        .fb_valid(fb_valid), .enable(enable), .fault_off(fault_off),
        .target_mv(target_mv), .out_off(out_off), .pwr_ok(pwr_ok)
    );

    // behavioural reference
    int m_q[$];
    int m_acc = 31;
    int m_fb = 0;
    bit m_pg = 0;
    int m_run = 0;

    function automatic int ref_mv(int c);
        if (c == 31) return 0;
        if (c < 16) return 1850 - 25 * c;
        return 1450 - 25 * (c - 16);
    endfunction

    always @(posedge clk) begin
        bit act;
        bit low;
        bit same;
        if (rst) begin
            m_q.delete();
            m_acc = 31; m_fb = 0; m_pg = 0; m_run = 0;
        end else begin
            act = enable && !fault_off && (m_acc != 31);
            low = (m_fb * 100) < (ref_mv(m_acc) * 88);
            if (!act) begin
                m_pg = 0; m_run = 0;
            end else if (!low) begin
                m_pg = 1; m_run = 0;
            end else if (m_pg) begin
                m_run++;
                if (m_run >= DLY) begin m_pg = 0; m_run = 0; end
            end
            if (fb_valid) m_fb = int'(fb_mv);
            m_q.push_back(int'(vid_code));
            if (m_q.size() > STB + 1) void'(m_q.pop_front());
            if (m_q.size() == STB + 1) begin
                same = 1;
                foreach (m_q[i]) if (m_q[i] != m_q[0]) same = 0;
                if (same) m_acc = m_q[0];
            end
        end
    end

    always @(negedge clk) begin
        if (checking && !rst && !done) begin
            vectors++;
            if (int'(target_mv) != ref_mv(m_acc)) begin
                fails++;
                $display("FAIL R1 R2 R3 (%s) target_mv got %0d exp %0d", cur_req, target_mv, ref_mv(m_acc));
            end
            if (out_off != (m_acc == 31)) begin
                fails++;
                $display("FAIL R2 (%s) out_off got %0d exp %0d", cur_req, out_off, m_acc == 31);
            end
            if (pwr_ok != m_pg) begin
                fails++;
                $display("FAIL R4 R5 R6 R7 R8 (%s) pwr_ok got %0d exp %0d", cur_req, pwr_ok, m_pg);
            end
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_fb(int v);
        fb_mv = 12'(v);
        fb_valid = 1'b1;
        @(negedge clk);
        fb_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R9 watchdog got timeout exp completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        cyc(3);
        rst = 1'b0;
        cyc(1);
        // R9: reset state
        vectors++;
        if (target_mv != 12'd0 || out_off != 1'b1 || pwr_ok != 1'b0) begin
            fails++;
            $display("FAIL R9 reset got t=%0d off=%0d pg=%0d exp t=0 off=1 pg=0", target_mv, out_off, pwr_ok);
        end
        checking = 1;

        cur_req = "R1 R5";
        vid_code = 5'd15; enable = 1'b1;
        set_fb(1500);
        cyc(10);

        cur_req = "R3 glitch";
        vid_code = 5'd0; cyc(3);
        vid_code = 5'd15; cyc(10);
        vid_code = 5'd3; cyc(STB); // exactly STB samples: not enough
        vid_code = 5'd15; cyc(10);

        cur_req = "R4 fb_valid low";
        fb_mv = 12'd10; cyc(5);

        cur_req = "R6 R8 drop";
        vid_code = 5'd0; cyc(DLY + 20);

        cur_req = "R5 return";
        set_fb(1700); cyc(5);

        cur_req = "R6 restart";
        set_fb(1600); cyc(20);
        set_fb(1700);
        set_fb(1600); cyc(30);
        cyc(DLY);

        cur_req = "R4 boundary";
        set_fb(1628); cyc(5);
        set_fb(1627); cyc(DLY + 5);
        set_fb(1628); cyc(5);

        cur_req = "R8 lower target";
        set_fb(1500);
        vid_code = 5'd15; cyc(10);

        cur_req = "R7 fault";
        fault_off = 1'b1; cyc(3);
        fault_off = 1'b0; cyc(3);
        enable = 1'b0; cyc(3);
        enable = 1'b1; cyc(3);

        cur_req = "R2 off";
        vid_code = 5'd31; cyc(10);

        cur_req = "R1 sweep";
        set_fb(4000);
        for (int c = 0; c < 32; c++) begin
            vid_code = 5'(c);
            cyc(STB + 4);
        end
        cyc(5);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule